// File: doc/BRIEF.md
# Cache/Mem Component Register File

This block is the 32-bit register file for the cache and memory part of a coherent-link component. It gives software a capability header array, a RAS error-control block, a link block and, for component kinds that need one, a memory-decoder block with a commit handshake on decoder 0. The component kind is a parameter. It decides how many capabilities the header array advertises, and so whether the decoder block exists at all.

Every stored register has a fixed per-bit write mask. A write replaces only the masked bits and keeps the old value in every other bit, so read-only fields never move. Only 4-byte accesses take effect. A wide (8-byte) access is marked by `reg_wide`: a wide read returns zero and a wide write is dropped. Addresses are word indices. Any address that belongs to no present register reads as zero and drops writes.

The register bus is a plain command interface with no back-pressure. A write takes effect at the clock edge where `reg_wr_en` is sampled. A read is always accepted: `reg_rvalid` is high exactly one cycle after `reg_rd_en`, and `reg_rdata` holds the value the register had before any write in the same cycle. `reg_rdata` holds its value until the next read.

Top module: `cm_regfile`

## Requirements
- R1: After reset, the uncorrectable mask (word 0x11) and the uncorrectable severity (word 0x12) read 0x0001CFFF, the correctable mask (word 0x14) reads 0x0000007F, both error status words (0x10, 0x13) read 0, decoder 0 control (word 0x4C) reads 0, and `reg_rvalid` is 0.
- R2: A read that is sampled in cycle t gives `reg_rvalid`=1 in cycle t+1, with `reg_rdata` equal to the register value before any write sampled in cycle t. `reg_rvalid` is 0 in a cycle that follows no read.
- R3: A 4-byte write stores (wdata AND mask) OR (old AND NOT mask). The masks are 0x1CFFF for words 0x11 and 0x12 and 0x7F for word 0x14. Words 0x10, 0x13 and 0x15 are read-only zero.
- R4: With `reg_wide`=1, a read returns 0 (with `reg_rvalid` still 1 in the next cycle) and a write changes no register.
- R5: Word 0 reads ID 1 in bits [15:0], version 1 in bits [19:16], cache/mem version 1 in bits [23:20] and the capability count in bits [31:24]. The count is 2 for downstream-port and plain-device kinds, 3 for upstream-port, memory-device and logical-device kinds, and 5 for root ports.
- R6: Words 1 to count hold the entries in this order: RAS (ID 2, version 2, pointer 0x010), link (4, 2, 0x020), memory decoder (5, 1, 0x040), extended security (6, 1, 0x060) and snoop (8, 1, 0x070). Each entry has ID in bits [15:0], version in bits [19:16] and the word pointer in bits [31:20].
- R7: The decoder capability word 0x40 is read-only 0x00000310. This encodes a decoder count code 0 (one decoder) in bits [3:0], target count 1 in bits [7:4], 256-byte interleave in bit 8, 4 KB interleave in bit 9, and no poison-on-error in bit 10.
- R8: The decoder global control word 0x41 resets to 0 and has write mask 0x3.
- R9: Decoder 0 base-low (0x48) and size-low (0x4A) have mask 0xF0000000. Base-high (0x49) and size-high (0x4B) are fully writable. Each further decoder's set sits 8 words higher.
- R10: Decoder 0 control (0x4C) has mask 0x13FF. When the merged value of a write has commit bit 9 set, the stored value has bit 9 cleared, error bit 11 cleared and committed bit 10 set. Bit 10 is not writable, so once set it stays set.
- R11: Header slots above the count, the link, extended-security and snoop regions, unused words such as 0x30, 0x4D and 0xFF, and the whole decoder region when the count is below 3 all read 0 and drop writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Write command, sampled on the rising edge |
| reg_rd_en | input | 1 | Read command, sampled on the rising edge |
| reg_wide | input | 1 | 1 marks an 8-byte access, which is not honoured |
| reg_addr | input | AW | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid when reg_rvalid is 1 |
| reg_rvalid | output | 1 | High one cycle after an accepted read |

## Verification
A write takes effect at the edge where it is sampled. A read result is registered once and appears one cycle after the read command. The bench therefore drives each command at a falling edge, removes it at the next falling edge, and samples `reg_rdata` and `reg_rvalid` at that second falling edge, half a cycle after the edge that loaded them. The commit corner case drives a write and a read in the same cycle. It expects the old control value in the first result and the committed value from a read issued one cycle later. A second instance of plain-device kind is read through its own data output to show that the header count and the decoder region change with the kind.

// File: rtl/cm_pkg.sv
package cm_pkg;

  typedef enum logic [2:0] {
    KIND_DSP,
    KIND_DEV,
    KIND_USP,
    KIND_MEMDEV,
    KIND_LOGDEV,
    KIND_ROOT
  } comp_kind_e;

  localparam int unsigned DW = 32;

  // word bases of the capability regions
  localparam int unsigned RAS_BASE  = 'h10;
  localparam int unsigned LINK_BASE = 'h20;
  localparam int unsigned HDM_BASE  = 'h40;
  localparam int unsigned XSEC_BASE = 'h60;
  localparam int unsigned SNP_BASE  = 'h70;

  // decoder control bit positions
  localparam int unsigned BIT_COMMIT    = 9;
  localparam int unsigned BIT_COMMITTED = 10;
  localparam int unsigned BIT_ERR       = 11;

  localparam int unsigned DEC_REGS = 5;

  typedef struct packed {
    logic [11:0] ptr;
    logic [3:0]  ver;
    logic [15:0] id;
  } cap_entry_t;

  function automatic int unsigned cap_count(comp_kind_e k);
    case (k)
      KIND_DSP, KIND_DEV:                return 2;
      KIND_USP, KIND_MEMDEV, KIND_LOGDEV: return 3;
      default:                           return 5;
    endcase
  endfunction

  function automatic cap_entry_t cap_entry(int unsigned slot);
    cap_entry_t e;
    e = '0;
    case (slot)
      1: begin e.id = 16'd2; e.ver = 4'd2; e.ptr = 12'(RAS_BASE);  end
      2: begin e.id = 16'd4; e.ver = 4'd2; e.ptr = 12'(LINK_BASE); end
      3: begin e.id = 16'd5; e.ver = 4'd1; e.ptr = 12'(HDM_BASE);  end
      4: begin e.id = 16'd6; e.ver = 4'd1; e.ptr = 12'(XSEC_BASE); end
      5: begin e.id = 16'd8; e.ver = 4'd1; e.ptr = 12'(SNP_BASE);  end
      default: e = '0;
    endcase
    return e;
  endfunction

  function automatic logic [3:0] dec_count_code(int unsigned n);
    case (n)
      1:       return 4'd0;
      2:       return 4'd1;
      4:       return 4'd2;
      8:       return 4'd3;
      default: return 4'd0;
    endcase
  endfunction

  // write mask per decoder register: base lo, base hi, size lo, size hi, control
  function automatic logic [DW-1:0] dec_mask(int unsigned k);
    case (k)
      0, 2:    return 32'hF000_0000;
      1, 3:    return 32'hFFFF_FFFF;
      4:       return 32'h0000_13FF;
      default: return 32'h0;
    endcase
  endfunction

endpackage

// File: rtl/cm_mreg.sv
module cm_mreg #(
  parameter int unsigned       W      = 32,
  parameter logic [W-1:0]      RST    = '0,
  parameter logic [W-1:0]      MASK   = '1,
  parameter bit                COMMIT = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  import cm_pkg::*;

  logic [W-1:0] merged;
  logic [W-1:0] nxt;

  assign merged = (wdata & MASK) | (q & ~MASK);

  generate
    if (COMMIT) begin : g_commit
      always_comb begin
        nxt = merged;
        if (merged[BIT_COMMIT]) begin
          nxt[BIT_COMMIT]    = 1'b0;
          nxt[BIT_ERR]       = 1'b0;
          nxt[BIT_COMMITTED] = 1'b1;
        end
      end
    end else begin : g_plain
      assign nxt = merged;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= RST;
    else if (wr) q <= nxt;
  end
endmodule

// File: rtl/cm_cap_hdr.sv
module cm_cap_hdr #(
  parameter cm_pkg::comp_kind_e KIND = cm_pkg::KIND_ROOT
) (
  input  logic [2:0]  slot,
  output logic [31:0] rdata
);
  import cm_pkg::*;

  localparam int unsigned NCAP = cap_count(KIND);

  always_comb begin
    rdata = '0;
    if (slot == 3'd0) begin
      rdata[15:0]  = 16'd1;
      rdata[19:16] = 4'd1;
      rdata[23:20] = 4'd1;
      rdata[31:24] = 8'(NCAP);
    end else if (int'(slot) <= int'(NCAP)) begin
      rdata = cap_entry(int'(slot));
    end
  end
endmodule

// File: rtl/cm_ras_blk.sv
module cm_ras_blk (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr,
  input  logic [3:0]  off,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic [31:0] unc_mask_q
);
  localparam logic [31:0] UNC_MASK = 32'h0001_CFFF;
  localparam logic [31:0] COR_MASK = 32'h0000_007F;

  logic [31:0] unc_sev_q;
  logic [31:0] cor_mask_q;

  cm_mreg #(.W(32), .RST(UNC_MASK), .MASK(UNC_MASK), .COMMIT(1'b0)) u_unc_mask (
    .clk(clk), .rst_n(rst_n), .wr(wr && off == 4'h1), .wdata(wdata), .q(unc_mask_q)
  );
  cm_mreg #(.W(32), .RST(UNC_MASK), .MASK(UNC_MASK), .COMMIT(1'b0)) u_unc_sev (
    .clk(clk), .rst_n(rst_n), .wr(wr && off == 4'h2), .wdata(wdata), .q(unc_sev_q)
  );
  cm_mreg #(.W(32), .RST(COR_MASK), .MASK(COR_MASK), .COMMIT(1'b0)) u_cor_mask (
    .clk(clk), .rst_n(rst_n), .wr(wr && off == 4'h4), .wdata(wdata), .q(cor_mask_q)
  );

  // status words and the capability/control word are read-only zero
  always_comb begin
    case (off)
      4'h1:    rdata = unc_mask_q;
      4'h2:    rdata = unc_sev_q;
      4'h4:    rdata = cor_mask_q;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/cm_hdm_blk.sv
module cm_hdm_blk #(
  parameter int unsigned N_DEC      = 1,
  parameter int unsigned DEC_STRIDE = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr,
  input  logic [4:0]  off,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic [31:0] gctrl_q,
  output logic [31:0] dec0_ctrl_q
);
  import cm_pkg::*;

  localparam int unsigned DEC_FIRST = 8;
  localparam logic [31:0] CAP_WORD  =
    {21'd0, 1'b0, 1'b1, 1'b1, 4'd1, dec_count_code(N_DEC)};

  logic [31:0] dq [N_DEC][DEC_REGS];

  cm_mreg #(.W(32), .RST(32'h0), .MASK(32'h3), .COMMIT(1'b0)) u_gctrl (
    .clk(clk), .rst_n(rst_n), .wr(wr && off == 5'd1), .wdata(wdata), .q(gctrl_q)
  );

  generate
    for (genvar i = 0; i < N_DEC; i++) begin : g_dec
      for (genvar k = 0; k < DEC_REGS; k++) begin : g_reg
        cm_mreg #(
          .W(32), .RST(32'h0), .MASK(dec_mask(k)), .COMMIT(k == 4)
        ) u_r (
          .clk(clk), .rst_n(rst_n),
          .wr(wr && off == 5'(DEC_FIRST + i*DEC_STRIDE + k)),
          .wdata(wdata), .q(dq[i][k])
        );
      end
    end
  endgenerate

  assign dec0_ctrl_q = dq[0][4];

  always_comb begin
    rdata = '0;
    if (off == 5'd0) rdata = CAP_WORD;
    if (off == 5'd1) rdata = gctrl_q;
    for (int i = 0; i < int'(N_DEC); i++) begin
      for (int k = 0; k < int'(DEC_REGS); k++) begin
        if (off == 5'(DEC_FIRST + i*DEC_STRIDE + k)) rdata = dq[i][k];
      end
    end
  end
endmodule

// File: rtl/cm_regfile.sv
module cm_regfile #(
  parameter cm_pkg::comp_kind_e KIND       = cm_pkg::KIND_ROOT,
  parameter int unsigned        AW         = 8,
  parameter int unsigned        N_DEC      = 1,
  parameter int unsigned        DEC_STRIDE = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr_en,
  input  logic          reg_rd_en,
  input  logic          reg_wide,
  input  logic [AW-1:0] reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          reg_rvalid
);
  import cm_pkg::*;

  localparam bit HAS_HDM = cap_count(KIND) >= 3;

  logic        hdr_sel, ras_sel, hdm_sel, wr_ok;
  logic [31:0] hdr_rdata, ras_rdata, hdm_rdata, rd_mux;
  logic [31:0] unc_mask_q, gctrl_q, dec0_ctrl_q;

  assign wr_ok   = reg_wr_en && !reg_wide;
  assign hdr_sel = reg_addr < AW'(8);
  assign ras_sel = reg_addr >= AW'(RAS_BASE) && reg_addr < AW'(RAS_BASE + 16);
  assign hdm_sel = HAS_HDM && reg_addr >= AW'(HDM_BASE) && reg_addr < AW'(HDM_BASE + 32);

  cm_cap_hdr #(.KIND(KIND)) u_hdr (
    .slot(reg_addr[2:0]), .rdata(hdr_rdata)
  );

  cm_ras_blk u_ras (
    .clk(clk), .rst_n(rst_n), .wr(wr_ok && ras_sel), .off(reg_addr[3:0]),
    .wdata(reg_wdata), .rdata(ras_rdata), .unc_mask_q(unc_mask_q)
  );

  generate
    if (HAS_HDM) begin : g_hdm
      cm_hdm_blk #(.N_DEC(N_DEC), .DEC_STRIDE(DEC_STRIDE)) u_hdm (
        .clk(clk), .rst_n(rst_n), .wr(wr_ok && hdm_sel), .off(reg_addr[4:0]),
        .wdata(reg_wdata), .rdata(hdm_rdata), .gctrl_q(gctrl_q),
        .dec0_ctrl_q(dec0_ctrl_q)
      );
    end else begin : g_no_hdm
      assign hdm_rdata   = '0;
      assign gctrl_q     = '0;
      assign dec0_ctrl_q = '0;
    end
  endgenerate

  always_comb begin
    rd_mux = '0;
    if (hdr_sel)      rd_mux = hdr_rdata;
    else if (ras_sel) rd_mux = ras_rdata;
    else if (hdm_sel) rd_mux = hdm_rdata;
    if (reg_wide)     rd_mux = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rdata  <= '0;
      reg_rvalid <= 1'b0;
    end else begin
      reg_rvalid <= reg_rd_en;
      if (reg_rd_en) reg_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/cm_regfile_chk.sv
module cm_regfile_chk #(
  parameter int unsigned AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr_en,
  input logic          reg_rd_en,
  input logic          reg_wide,
  input logic [AW-1:0] reg_addr,
  input logic [31:0]   reg_wdata,
  input logic [31:0]   reg_rdata,
  input logic          reg_rvalid,
  input logic [31:0]   unc_mask_q,
  input logic [31:0]   gctrl_q,
  input logic [31:0]   dec0_ctrl_q,
  input logic          hdm_on
);
  // R2
  rvalid_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_en |=> reg_rvalid);
  // R2
  rvalid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd_en |=> !reg_rvalid);
  // R4
  wide_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_en && reg_wide |=> reg_rdata == 32'h0);
  // R4
  wide_write_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en && reg_wide |=> $stable(unc_mask_q) && $stable(gctrl_q) && $stable(dec0_ctrl_q));
  // R8
  gctrl_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gctrl_q[31:2] == 30'h0);
  // R10
  commit_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hdm_on && reg_wr_en && !reg_wide && reg_addr == AW'('h4C) && reg_wdata[9]
    |=> dec0_ctrl_q[10] && !dec0_ctrl_q[9] && !dec0_ctrl_q[11]);
  // R10
  committed_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec0_ctrl_q[10] |=> dec0_ctrl_q[10]);
  // R11
  hole_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_en && reg_addr == AW'('h30) |=> reg_rdata == 32'h0);
endmodule

bind cm_regfile cm_regfile_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
  .reg_wide(reg_wide), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid), .unc_mask_q(unc_mask_q),
  .gctrl_q(gctrl_q), .dec0_ctrl_q(dec0_ctrl_q), .hdm_on(HAS_HDM)
);

// File: tb/cm_regfile_tb.sv
module cm_regfile_tb;
  import cm_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0, wide = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, rdata2;
  logic        rvalid, rvalid2;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  cm_regfile #(.KIND(KIND_ROOT), .AW(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(wr_en), .reg_rd_en(rd_en),
    .reg_wide(wide), .reg_addr(addr), .reg_wdata(wdata),
    .reg_rdata(rdata), .reg_rvalid(rvalid)
  );

  cm_regfile #(.KIND(KIND_DEV), .AW(8)) u_dut2 (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(wr_en), .reg_rd_en(rd_en),
    .reg_wide(wide), .reg_addr(addr), .reg_wdata(wdata),
    .reg_rdata(rdata2), .reg_rvalid(rvalid2)
  );

  typedef struct packed {
    logic        wr;
    logic [7:0]  a;
    logic [31:0] d;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 32;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 8'h00, 32'h0,         32'h0511_0001, 8'd5},  // R5
    '{1'b0, 8'h01, 32'h0,         32'h0102_0002, 8'd6},  // R6
    '{1'b0, 8'h02, 32'h0,         32'h0202_0004, 8'd6},
    '{1'b0, 8'h03, 32'h0,         32'h0401_0005, 8'd6},
    '{1'b0, 8'h04, 32'h0,         32'h0601_0006, 8'd6},
    '{1'b0, 8'h05, 32'h0,         32'h0701_0008, 8'd6},
    '{1'b0, 8'h06, 32'h0,         32'h0,         8'd11}, // R11
    '{1'b0, 8'h11, 32'h0,         32'h0001_CFFF, 8'd1},  // R1
    '{1'b0, 8'h12, 32'h0,         32'h0001_CFFF, 8'd1},
    '{1'b0, 8'h14, 32'h0,         32'h0000_007F, 8'd1},
    '{1'b0, 8'h10, 32'h0,         32'h0,         8'd1},
    '{1'b0, 8'h13, 32'h0,         32'h0,         8'd1},
    '{1'b1, 8'h11, 32'h0,         32'h0,         8'd3},  // R3
    '{1'b1, 8'h11, 32'hFFFF_FFFF, 32'h0001_CFFF, 8'd3},
    '{1'b1, 8'h14, 32'hFFFF_FF00, 32'h0,         8'd3},
    '{1'b1, 8'h10, 32'hFFFF_FFFF, 32'h0,         8'd3},
    '{1'b1, 8'h12, 32'h0001_0A5A, 32'h0001_0A5A, 8'd3},
    '{1'b0, 8'h40, 32'h0,         32'h0000_0310, 8'd7},  // R7
    '{1'b1, 8'h40, 32'hFFFF_FFFF, 32'h0000_0310, 8'd7},
    '{1'b0, 8'h41, 32'h0,         32'h0,         8'd8},  // R8
    '{1'b1, 8'h41, 32'hFFFF_FFFF, 32'h0000_0003, 8'd8},
    '{1'b1, 8'h48, 32'hFFFF_FFFF, 32'hF000_0000, 8'd9},  // R9
    '{1'b1, 8'h49, 32'h1234_5678, 32'h1234_5678, 8'd9},
    '{1'b1, 8'h4A, 32'h1234_5678, 32'h1000_0000, 8'd9},
    '{1'b1, 8'h4B, 32'hA5A5_A5A5, 32'hA5A5_A5A5, 8'd9},
    '{1'b1, 8'h4C, 32'h0000_00FF, 32'h0000_00FF, 8'd10}, // R10
    '{1'b1, 8'h4C, 32'hFFFF_FFFF, 32'h0000_15FF, 8'd10},
    '{1'b1, 8'h4C, 32'h0,         32'h0000_0400, 8'd10},
    '{1'b1, 8'h30, 32'hFFFF_FFFF, 32'h0,         8'd11}, // R11
    '{1'b1, 8'hFF, 32'hFFFF_FFFF, 32'h0,         8'd11},
    '{1'b1, 8'h15, 32'hFFFF_FFFF, 32'h0,         8'd3},
    '{1'b1, 8'h4D, 32'hFFFF_FFFF, 32'h0,         8'd11}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] a, input logic [31:0] d, input logic w);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d; wide = w;
    @(negedge clk);
    wr_en = 1'b0; wide = 1'b0;
  endtask

  task automatic do_read(input logic [7:0] a, input logic w);
    @(negedge clk);
    rd_en = 1'b1; addr = a; wide = w;
    @(negedge clk);
    rd_en = 1'b0; wide = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 rvalid at reset", {31'd0, rvalid}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].wr) do_write(VEC[i].a, VEC[i].d, 1'b0);
      do_read(VEC[i].a, 1'b0);
      check($sformatf("R%0d vector %0d addr %h", VEC[i].req, i, VEC[i].a), rdata, VEC[i].exp);
    end

    // R2: read result valid one cycle after command, idle afterwards
    do_read(8'h11, 1'b0);
    check("R2 rvalid after read", {31'd0, rvalid}, 32'h1);
    @(negedge clk);
    check("R2 rvalid idle", {31'd0, rvalid}, 32'h0);

    // R2 and R10: same-cycle write with commit and read of decoder control
    @(negedge clk);
    wr_en = 1'b1; rd_en = 1'b1; addr = 8'h4C; wdata = 32'h0000_0201;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    check("R2 pre-write value on same-cycle read", rdata, 32'h0000_0400);
    do_read(8'h4C, 1'b0);
    check("R10 committed value next cycle", rdata, 32'h0000_0401);

    // R4: wide write dropped, wide read returns zero
    do_write(8'h11, 32'h0, 1'b1);
    do_read(8'h11, 1'b0);
    check("R4 wide write dropped", rdata, 32'h0001_CFFF);
    do_read(8'h00, 1'b1);
    check("R4 wide read zero", rdata, 32'h0);
    check("R4 wide read rvalid", {31'd0, rvalid}, 32'h1);

    // R5 and R11 on the plain-device instance
    do_read(8'h00, 1'b0);
    check("R5 device header count 2", rdata2, 32'h0211_0001);
    do_read(8'h02, 1'b0);
    check("R6 device link entry", rdata2, 32'h0202_0004);
    do_read(8'h03, 1'b0);
    check("R11 device slot 3 absent", rdata2, 32'h0);
    do_read(8'h40, 1'b0);
    check("R11 device decoder cap absent", rdata2, 32'h0);
    do_write(8'h41, 32'h3, 1'b0);
    do_read(8'h41, 1'b0);
    check("R11 device gctrl write dropped", rdata2, 32'h0);

    // R1: reset restores values
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    do_read(8'h12, 1'b0);
    check("R1 severity after reset", rdata, 32'h0001_CFFF);
    do_read(8'h4C, 1'b0);
    check("R1 decoder control after reset", rdata, 32'h0);
    do_read(8'h41, 1'b0);
    check("R8 gctrl after reset", rdata, 32'h0);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule